// File: doc/BRIEF.md
# Cross-Port Mailbox Register Pair

This block gives two independently clocked data ports a side channel for command words. The side channel runs next to a FIFO that is not part of the block. Port A posts words into mailbox 1 and collects words from mailbox 2. Port B does the reverse: it posts into mailbox 2 and collects from mailbox 1.

A per-port mailbox-select input decides whether a transfer goes to the mailbox or to the FIFO. On port B the same select also steers the read bus, so that it carries either the FIFO output word or mailbox 1.

Each mailbox has a status flag in its writer's clock domain. The flag is high while the mailbox is free and low while it holds a word the other side has not yet collected. A word is posted by the writer's clock. It is released by the reader's clock. The release crosses back through a synchronizer built from toggle bits. While a mailbox is occupied, further posts to it are refused. Collecting a word leaves the stored value untouched.

Top module: `xport_mailbox`

## Requirements
- R1: After reset both free flags (`a_box1_free`, `b_box2_free`) are 1 and both mailboxes hold zero, so `a_rdata` is 0 and `b_rdata` is 0 while `b_mbox` is 1.
- R2: An accepted port-A post stores `a_wdata` into mailbox 1 at that clock A edge. A post is accepted when `a_sel`, `a_wr`, `a_en` and `a_mbox` are all 1 and `a_box1_free` is 1. The stored word appears on `b_rdata` whenever `b_mbox` is 1.
- R3: An accepted port-B post stores `b_wdata` into mailbox 2 at that clock B edge. A post is accepted when `b_sel`, `b_wr`, `b_en` and `b_mbox` are all 1 and `b_box2_free` is 1. The stored word appears on `a_rdata`.
- R4: An accepted post drives the writer's free flag to 0 at the same edge that stores the word.
- R5: A post attempted while the writer's free flag is 0 is refused. The mailbox contents stay unchanged and the flag stays 0.
- R6: A collect is a transfer with select, enable and mailbox select at 1 and the write bit at 0. On port B it acts on mailbox 1; on port A it acts on mailbox 2. A collect of a word that has reached the reader's domain returns the writer's free flag to 1 within SYNC_STAGES+1 writer clock edges.
- R7: When `b_mbox` is 0, `b_rdata` equals `b_fifo_data`.
- R8: Collecting a mailbox leaves its contents unchanged. Only an accepted post changes them.
- R9: A transfer with `a_mbox` or `b_mbox` at 0, or with select or enable at 0, changes neither the mailboxes nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| clk_a | input | 1 | Port A clock |
| a_sel | input | 1 | Port A select |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A transfer enable |
| a_mbox | input | 1 | Port A target, 1 = mailbox, 0 = FIFO |
| a_wdata | input | DATA_W | Port A write word |
| a_rdata | output | DATA_W | Mailbox 2 contents |
| a_box1_free | output | 1 | Mailbox 1 free flag (low = unread word) |
| clk_b | input | 1 | Port B clock |
| b_sel | input | 1 | Port B select |
| b_wr | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B transfer enable |
| b_mbox | input | 1 | Port B target, 1 = mailbox, 0 = FIFO |
| b_wdata | input | DATA_W | Port B write word |
| b_fifo_data | input | DATA_W | FIFO output word |
| b_rdata | output | DATA_W | Port B read bus (mailbox 1 or FIFO word) |
| b_box2_free | output | 1 | Mailbox 2 free flag (low = unread word) |

## Verification
The collision of interest is a writer retrying a post on the same clock A edge on which the synchronized release from port B arrives. At that edge the refusal logic and the acceptance logic meet.

The bench provokes this by having port B collect mailbox 1 and then having port A attempt a post on every following clock A cycle. It judges the outcome by the final state. Exactly the new word must be on `b_rdata`, and `a_box1_free` must be 0 once the loop ends. The refused attempts before that edge must not disturb the old word.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   // Decoded request of one port toward its mailbox pair.
   typedef struct packed {
      logic post;     // write toward the outgoing mailbox
      logic collect;  // read of the incoming mailbox
   } mb_req_t;

   function automatic mb_req_t decode_req(input logic sel, input logic wr,
                                          input logic en, input logic mbox);
      mb_req_t r;
      r.post    = sel & en & mbox & wr;
      r.collect = sel & en & mbox & ~wr;
      return r;
   endfunction

endpackage

// File: rtl/xmb_port_decode.sv
module xmb_port_decode
   import xmb_pkg::*;
(
   input  logic    sel,
   input  logic    wr,
   input  logic    en,
   input  logic    mbox,
   output mb_req_t req
);
   always_comb req = decode_req(sel, wr, en, mbox);
endmodule

// File: rtl/xmb_sync.sv
module xmb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xmb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xmb_channel.sv
// One mailbox: storage and post toggle live in the writer domain;
// the collect toggle lives in the reader domain.
module xmb_channel #(
   parameter int DW          = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rst_n,
   input  logic          wclk,
   input  logic          post,
   input  logic [DW-1:0] wdata,
   output logic          free,
   output logic [DW-1:0] data_q,
   input  logic          rclk,
   input  logic          collect
);
   if (DW < 1) begin : g_bad_width
      $error("xmb_channel: DW must be positive");
   end

   logic post_tog_q;     // writer domain
   logic coll_tog_q;     // reader domain
   logic post_tog_rd;    // post toggle seen by reader
   logic coll_tog_wr;    // collect toggle seen by writer
   logic pending_rd;
   logic accept;

   assign free    = (post_tog_q == coll_tog_wr);
   assign accept  = post & free;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         post_tog_q <= 1'b0;
         data_q     <= '0;
      end else if (accept) begin
         post_tog_q <= ~post_tog_q;
         data_q     <= wdata;
      end
   end

   xmb_sync #(.STAGES(SYNC_STAGES)) u_to_rd (
      .clk(rclk), .rst_n(rst_n), .d(post_tog_q), .q(post_tog_rd));

   assign pending_rd = (post_tog_rd != coll_tog_q);

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)                       coll_tog_q <= 1'b0;
      else if (collect && pending_rd)   coll_tog_q <= ~coll_tog_q;
   end

   xmb_sync #(.STAGES(SYNC_STAGES)) u_to_wr (
      .clk(wclk), .rst_n(rst_n), .d(coll_tog_q), .q(coll_tog_wr));
endmodule

// File: rtl/xport_mailbox.sv
module xport_mailbox
   import xmb_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              clk_a,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic              a_en,
   input  logic              a_mbox,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_box1_free,
   input  logic              clk_b,
   input  logic              b_sel,
   input  logic              b_wr,
   input  logic              b_en,
   input  logic              b_mbox,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic [DATA_W-1:0] b_fifo_data,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_box2_free
);
   mb_req_t           a_req, b_req;
   logic [DATA_W-1:0] mb1_q, mb2_q;

   xmb_port_decode u_dec_a (.sel(a_sel), .wr(a_wr), .en(a_en), .mbox(a_mbox), .req(a_req));
   xmb_port_decode u_dec_b (.sel(b_sel), .wr(b_wr), .en(b_en), .mbox(b_mbox), .req(b_req));

   // Mailbox 1: A posts, B collects.
   xmb_channel #(.DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box1 (
      .rst_n(rst_n), .wclk(clk_a), .post(a_req.post), .wdata(a_wdata),
      .free(a_box1_free), .data_q(mb1_q), .rclk(clk_b), .collect(b_req.collect));

   // Mailbox 2: B posts, A collects.
   xmb_channel #(.DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box2 (
      .rst_n(rst_n), .wclk(clk_b), .post(b_req.post), .wdata(b_wdata),
      .free(b_box2_free), .data_q(mb2_q), .rclk(clk_a), .collect(a_req.collect));

   assign a_rdata = mb2_q;
   assign b_rdata = b_mbox ? mb1_q : b_fifo_data;
endmodule

// File: rtl/xmb_chk.sv
module xmb_chk #(
   parameter int DATA_W = 36
) (
   input logic              rst_n,
   input logic              clk_a,
   input logic              a_sel,
   input logic              a_wr,
   input logic              a_en,
   input logic              a_mbox,
   input logic [DATA_W-1:0] a_wdata,
   input logic              a_box1_free,
   input logic              clk_b,
   input logic              b_sel,
   input logic              b_wr,
   input logic              b_en,
   input logic              b_mbox,
   input logic [DATA_W-1:0] b_wdata,
   input logic              b_box2_free,
   input logic [DATA_W-1:0] mb1_q,
   input logic [DATA_W-1:0] mb2_q
);
   logic a_try, b_try;
   assign a_try = a_sel & a_wr & a_en & a_mbox;
   assign b_try = b_sel & b_wr & b_en & b_mbox;

   // R4
   a_post_clears_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_try && a_box1_free) |=> !a_box1_free);
   // R4
   b_post_clears_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_try && b_box2_free) |=> !b_box2_free);
   // R2
   a_post_stores_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_try && a_box1_free) |=> (mb1_q == $past(a_wdata)));
   // R3
   b_post_stores_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_try && b_box2_free) |=> (mb2_q == $past(b_wdata)));
   // R5
   box1_held_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      !a_box1_free |=> $stable(mb1_q));
   // R5
   box2_held_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      !b_box2_free |=> $stable(mb2_q));
endmodule

bind xport_mailbox xmb_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/xport_mailbox_tb.sv
module xport_mailbox_tb;
   localparam int DW = 36;

   logic rst_n = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
   logic a_sel = 0, a_wr = 0, a_en = 0, a_mbox = 0;
   logic b_sel = 0, b_wr = 0, b_en = 0, b_mbox = 0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0, b_fifo_data = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic a_box1_free, b_box2_free;

   always #10 clk_a = ~clk_a;   // 50 MHz
   always #13 clk_b = ~clk_b;

   xport_mailbox #(.DATA_W(DW)) u_dut (.*);

   typedef enum int {OBS_ARD, OBS_BRD, OBS_AFREE, OBS_BFREE} obs_e;
   typedef struct { string req; obs_e obs; logic [DW-1:0] exp; } item_t;
   item_t q[$];
   int total = 0, bad = 0;
   bit done = 0;

   // Monitor: pops expected items and compares against the ports.
   initial forever begin
      item_t it;
      logic [DW-1:0] act;
      while (q.size() == 0) #1;
      it = q.pop_front();
      case (it.obs)
         OBS_ARD:   act = a_rdata;
         OBS_BRD:   act = b_rdata;
         OBS_AFREE: act = {{(DW-1){1'b0}}, a_box1_free};
         default:   act = {{(DW-1){1'b0}}, b_box2_free};
      endcase
      total++;
      if (act !== it.exp) begin
         bad++;
         $display("FAIL %s obs=%s actual=%h expected=%h", it.req, it.obs.name(), act, it.exp);
      end
   end

   // Driver side: push an expectation and wait for the monitor.
   task automatic expect_val(string req, obs_e obs, logic [DW-1:0] exp);
      item_t it;
      it.req = req; it.obs = obs; it.exp = exp;
      q.push_back(it);
      while (q.size() != 0) #1;
      #1;
   endtask

   task automatic a_xfer(logic wr, logic mbox, logic en, logic [DW-1:0] d);
      @(negedge clk_a);
      a_sel = 1; a_wr = wr; a_en = en; a_mbox = mbox; a_wdata = d;
      @(negedge clk_a);
      a_sel = 0; a_en = 0; a_wr = 0; a_mbox = 0;
   endtask

   task automatic b_xfer(logic wr, logic en, logic [DW-1:0] d);
      @(negedge clk_b);
      b_sel = 1; b_wr = wr; b_en = en; b_mbox = 1; b_wdata = d;
      @(negedge clk_b);
      b_sel = 0; b_en = 0; b_wr = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_a);
      rst_n = 1;
      @(negedge clk_a);
      b_mbox = 1;
      // R1 reset state
      expect_val("R1", OBS_AFREE, 1);
      expect_val("R1", OBS_BFREE, 1);
      expect_val("R1", OBS_ARD, 0);
      expect_val("R1", OBS_BRD, 0);

      // R7 FIFO word on port B when mailbox select low
      b_mbox = 0; b_fifo_data = 36'h123456789;
      expect_val("R7", OBS_BRD, 36'h123456789);
      b_fifo_data = 36'hFEDCBA987;
      expect_val("R7", OBS_BRD, 36'hFEDCBA987);

      // R9 FIFO-targeted and disabled writes leave mailbox alone
      a_xfer(1, 0, 1, 36'hAAAAAAAAA);
      a_xfer(1, 1, 0, 36'h555555555);
      expect_val("R9", OBS_AFREE, 1);
      b_mbox = 1;
      expect_val("R9", OBS_BRD, 0);

      // R2, R4 accepted post to mailbox 1
      a_xfer(1, 1, 1, 36'h0C0FFEE01);
      expect_val("R4", OBS_AFREE, 0);
      expect_val("R2", OBS_BRD, 36'h0C0FFEE01);

      // R5 refused post while occupied
      a_xfer(1, 1, 1, 36'hBADBADBAD);
      expect_val("R5", OBS_BRD, 36'h0C0FFEE01);
      expect_val("R5", OBS_AFREE, 0);

      // R6, R8 collect on port B releases flag, keeps data
      repeat (4) @(negedge clk_b);
      b_xfer(0, 1, '0);
      expect_val("R8", OBS_BRD, 36'h0C0FFEE01);
      repeat (3) @(negedge clk_a);
      expect_val("R6", OBS_AFREE, 1);

      // R3, R4, R5 on mailbox 2
      b_xfer(1, 1, 36'h00000BEEF);
      expect_val("R4", OBS_BFREE, 0);
      expect_val("R3", OBS_ARD, 36'h00000BEEF);
      b_xfer(1, 1, 36'h0DEADDEAD);
      expect_val("R5", OBS_ARD, 36'h00000BEEF);
      repeat (4) @(negedge clk_a);
      a_xfer(0, 1, 1, '0);
      expect_val("R8", OBS_ARD, 36'h00000BEEF);
      repeat (3) @(negedge clk_b);
      expect_val("R6", OBS_BFREE, 1);

      // Collision: retry posts every A cycle while release is in flight
      a_xfer(1, 1, 1, 36'h111111111);
      repeat (4) @(negedge clk_b);
      b_xfer(0, 1, '0);
      @(negedge clk_a);
      a_sel = 1; a_wr = 1; a_en = 1; a_mbox = 1; a_wdata = 36'h222222222;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk_a);
         if (!a_box1_free) break;
      end
      a_sel = 0; a_en = 0; a_wr = 0; a_mbox = 0;
      expect_val("R2", OBS_BRD, 36'h222222222);
      expect_val("R5", OBS_AFREE, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule